// File: doc/BRIEF.md
# Network Controller Command/Status Register

This block holds the main command and status word of a DMA-based network controller and sequences its start, stop and initialization. A host writes command bits through a simple write strobe and reads back a status byte. The rest of the controller reports events into the block: the initialization block has finished loading, a transmit descriptor was fetched, a transmit underflow occurred, and a vector of individual interrupt flags with their masks. From these the block drives the receive, transmit and DMA enable levels, a one-cycle initialization request, a transmit-ring access request and an active-low interrupt pin.

The command bits are write-one-to-set and interlock with each other. Stop wins over every other command. When start and init are written together, the receive and transmit enables wait until initialization has completed. A soft reset input has the same effect as writing stop, while `rst_n` is the asynchronous hard reset.

Top module: `netctl_csr`

Status byte layout (`csr_rd`, also the meaning of each `wr_data` bit on a write): bit 0 init, bit 1 start, bit 2 stop, bit 3 transmit demand, bit 4 transmit-on, bit 5 receive-on, bit 6 interrupt enable, bit 7 interrupt summary.

## Requirements
- R1: After hard reset, stop reads 1 and all other status bits, `rx_en`, `tx_en`, `dma_en`, `init_req` and `txring_req` read 0, and `irq_n` is 1 while no flag or forced source is active.
- R2: A write with bit 2 set, on the next edge, sets stop and clears start, init, transmit demand, receive-on, transmit-on and interrupt enable. This holds even if bits 0 and 1 are set in the same write. Writing 0 to bit 2 leaves stop unchanged.
- R3: A write with bit 1 set and bit 2 clear sets start and clears stop on the next edge. `dma_en` equals the inverse of stop.
- R4: When start is newly set and no initialization is pending, receive-on becomes the inverse of `rx_disable` and transmit-on becomes the inverse of `tx_disable`, one edge after start is seen.
- R5: When start and init are written together, receive-on and transmit-on stay 0 until `init_done` has been seen. They take their values on the edge after the one on which `init_done` is sampled.
- R6: A write with bit 0 set and bit 2 clear sets init, clears stop and, if init was 0, raises `init_req` for exactly one cycle.
- R7: A `tx_underflow` pulse clears transmit-on when `uflo_keep_tx` is 0, and leaves it unchanged when `uflo_keep_tx` is 1.
- R8: Transmit demand is set by writing 1 to bit 3 while transmit-on is 1, and writing 0 to it has no effect. It clears on `txd_fetched`, and it clears (or is never set) on any cycle in which transmit-on is 0.
- R9: `txring_req` is 1 when transmit demand is 1, or when `poll_tick` is 1 while transmit-on is 1.
- R10: Every write loads interrupt enable from bit 6, unless bit 2 is set in that write, in which case it clears.
- R11: The interrupt summary (bit 7) is the OR of `irq_flags` bits whose `irq_mask` bit is 0. A mask bit of 1 hides its flag.
- R12: `irq_n` is 0 when interrupt enable and the summary are both 1, or when `irq_force` is 1. Otherwise it is 1.
- R13: A `soft_rst` pulse has the effect of a stop write and takes priority over any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| soft_rst | input | 1 | Synchronous soft reset pulse |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write data, bit layout as the status byte |
| init_done | input | 1 | Initialization block load complete |
| txd_fetched | input | 1 | Transmit descriptor fetched |
| tx_underflow | input | 1 | Transmit underflow event |
| uflo_keep_tx | input | 1 | 1 keeps transmit-on through an underflow |
| rx_disable | input | 1 | Receive disable configuration |
| tx_disable | input | 1 | Transmit disable configuration |
| poll_tick | input | 1 | Transmit poll timer expiry |
| irq_flags | input | NIRQ | Individual interrupt flags |
| irq_mask | input | NIRQ | Per-flag mask, 1 hides the flag |
| irq_force | input | 1 | Exception source that bypasses interrupt enable |
| csr_rd | output | 8 | Status byte |
| rx_en | output | 1 | Receive enable (receive-on) |
| tx_en | output | 1 | Transmit enable (transmit-on) |
| dma_en | output | 1 | DMA enable |
| init_req | output | 1 | One-cycle initialization request |
| txring_req | output | 1 | Transmit-ring access request |
| irq_n | output | 1 | Active-low interrupt pin |

## Verification
The assertions assume that `init_done` and `txd_fetched` are single-cycle event pulses. They also assume that a soft reset and a stop write have the same effect, so any cycle with either one leads into the stopped state. The stimulus applies events as pulses of one cycle, and random writes use stop only rarely so that the running states are reached. Directed phases cover the write combinations that set several command bits at once. They also cover the delayed `init_done` and underflow with both settings of the keep bit.

// File: rtl/netctl_csr.sv
module netctl_csr #(
  parameter int NIRQ = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic            wr_en,
  input  logic [7:0]      wr_data,
  input  logic            init_done,
  input  logic            txd_fetched,
  input  logic            tx_underflow,
  input  logic            uflo_keep_tx,
  input  logic            rx_disable,
  input  logic            tx_disable,
  input  logic            poll_tick,
  input  logic [NIRQ-1:0] irq_flags,
  input  logic [NIRQ-1:0] irq_mask,
  input  logic            irq_force,
  output logic [7:0]      csr_rd,
  output logic            rx_en,
  output logic            tx_en,
  output logic            dma_en,
  output logic            init_req,
  output logic            txring_req,
  output logic            irq_n
);

  logic stop_q, start_q, init_q, tdmd_q, rx_on_q, tx_on_q, ie_q;
  logic arm_q, busy_q, init_req_q;

  wire stop_cmd = soft_rst | (wr_en & wr_data[2]);
  wire wr_init  = wr_en & wr_data[0];
  wire wr_start = wr_en & wr_data[1];
  wire wr_tdmd  = wr_en & wr_data[3];
  wire new_init = wr_init & ~init_q;
  wire release_en = arm_q & ~busy_q;
  wire intr = |(irq_flags & ~irq_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b1;
      {start_q, init_q, tdmd_q, rx_on_q, tx_on_q, ie_q} <= '0;
      {arm_q, busy_q, init_req_q} <= '0;
    end else if (stop_cmd) begin
      stop_q <= 1'b1;
      {start_q, init_q, tdmd_q, rx_on_q, tx_on_q, ie_q} <= '0;
      {arm_q, busy_q, init_req_q} <= '0;
    end else begin
      if (wr_init || wr_start) stop_q <= 1'b0;
      if (wr_init) init_q <= 1'b1;
      if (wr_start) start_q <= 1'b1;
      if (wr_en) ie_q <= wr_data[6];
      init_req_q <= new_init;
      busy_q <= new_init | (busy_q & ~init_done);
      if (wr_start && !start_q) arm_q <= 1'b1;
      else if (release_en) arm_q <= 1'b0;
      if (release_en) rx_on_q <= ~rx_disable;
      if (tx_underflow && !uflo_keep_tx) tx_on_q <= 1'b0;
      else if (release_en) tx_on_q <= ~tx_disable;
      tdmd_q <= (tdmd_q | wr_tdmd) & tx_on_q & ~txd_fetched;
    end
  end

  assign csr_rd     = {intr, ie_q, rx_on_q, tx_on_q, tdmd_q, stop_q, start_q, init_q};
  assign rx_en      = rx_on_q;
  assign tx_en      = tx_on_q;
  assign dma_en     = ~stop_q;
  assign init_req   = init_req_q;
  assign txring_req = tdmd_q | (poll_tick & tx_on_q);
  assign irq_n      = ~((ie_q & intr) | irq_force);

  a_r2_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[2]) |=> (stop_q && !start_q && !init_q && !ie_q));

  a_r3_start_clears_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[1] && !wr_data[2] && !soft_rst) |=> (start_q && !stop_q));

  a_r4_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |-> (!rx_on_q && !tx_on_q && !tdmd_q));

  a_r6_init_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    init_req_q |=> !init_req_q);

  a_r8_tdmd_needs_tx: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_on_q |=> !tdmd_q);

  a_r13_soft_stops: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (stop_q && !start_q && !rx_on_q && !tx_on_q));

endmodule

// File: tb/netctl_csr_bench.sv
module netctl_csr_bench;
  localparam int NIRQ = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 0, wr_en = 0, init_done = 0, txd_fetched = 0, tx_underflow = 0;
  logic uflo_keep_tx = 0, rx_disable = 0, tx_disable = 0, poll_tick = 0, irq_force = 0;
  logic [7:0] wr_data = '0;
  logic [NIRQ-1:0] irq_flags = '0, irq_mask = '0;
  logic [7:0] csr_rd;
  logic rx_en, tx_en, dma_en, init_req, txring_req, irq_n;

  int vectors = 0;
  int misses = 0;
  bit done = 0;

  always #5 clk = ~clk;

  netctl_csr #(.NIRQ(NIRQ)) u_netctl_csr (
    .clk, .rst_n, .soft_rst, .wr_en, .wr_data, .init_done, .txd_fetched,
    .tx_underflow, .uflo_keep_tx, .rx_disable, .tx_disable, .poll_tick,
    .irq_flags, .irq_mask, .irq_force, .csr_rd, .rx_en, .tx_en, .dma_en,
    .init_req, .txring_req, .irq_n
  );

  // reference state
  bit m_stop = 1, m_start, m_init, m_tdmd, m_rx, m_tx, m_ie, m_req;
  bit m_wait_init, m_waiting_start;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stop = 1; m_start = 0; m_init = 0; m_tdmd = 0; m_rx = 0; m_tx = 0;
      m_ie = 0; m_req = 0; m_wait_init = 0; m_waiting_start = 0;
    end else if (soft_rst || (wr_en && wr_data[2])) begin
      m_stop = 1; m_start = 0; m_init = 0; m_tdmd = 0; m_rx = 0; m_tx = 0;
      m_ie = 0; m_req = 0; m_wait_init = 0; m_waiting_start = 0;
    end else begin
      bit go, old_tx, fresh_init;
      go = m_waiting_start && !m_wait_init;
      old_tx = m_tx;
      fresh_init = wr_en && wr_data[0] && !m_init;
      m_req = fresh_init;
      if (wr_en && (wr_data[0] || wr_data[1])) m_stop = 0;
      if (wr_en && wr_data[6]) m_ie = 1; else if (wr_en) m_ie = 0;
      if (init_done) m_wait_init = 0;
      if (fresh_init) m_wait_init = 1;
      if (go) begin
        m_waiting_start = 0;
        m_rx = !rx_disable;
        m_tx = !tx_disable;
      end
      if (wr_en && wr_data[1] && !m_start) m_waiting_start = 1;
      if (tx_underflow && !uflo_keep_tx) m_tx = 0;
      if (wr_en && wr_data[3]) m_tdmd = 1;
      if (txd_fetched || !old_tx) m_tdmd = 0;
      if (wr_en && wr_data[0]) m_init = 1;
      if (wr_en && wr_data[1]) m_start = 1;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit summ;
    summ = |(irq_flags & ~irq_mask);
    chk("R6 init bit", csr_rd[0], m_init);
    chk("R3 start bit", csr_rd[1], m_start);
    chk("R2 stop bit", csr_rd[2], m_stop);
    chk("R8 tx demand", csr_rd[3], m_tdmd);
    chk("R4 R5 R7 tx-on", csr_rd[4], m_tx);
    chk("R4 R5 rx-on", csr_rd[5], m_rx);
    chk("R10 int enable", csr_rd[6], m_ie);
    chk("R11 summary", csr_rd[7], summ);
    chk("R4 rx_en", rx_en, m_rx);
    chk("R4 tx_en", tx_en, m_tx);
    chk("R3 dma_en", dma_en, !m_stop);
    chk("R6 init_req", init_req, m_req);
    chk("R9 txring_req", txring_req, m_tdmd || (poll_tick && m_tx));
    chk("R12 irq_n", irq_n, !((m_ie && summ) || irq_force));
  endtask

  // compare at the falling edge, then drive the next inputs
  task automatic step(bit w = 0, logic [7:0] d = 0);
    @(negedge clk);
    compare_all();
    wr_en = w; wr_data = d;
    soft_rst = 0; init_done = 0; txd_fetched = 0; tx_underflow = 0; poll_tick = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #1_000_000;
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset csr", csr_rd, 8'h04);
    chk("R1 reset irq_n", irq_n, 1'b1);
    chk("R1 reset dma_en", dma_en, 1'b0);
    rst_n = 1;
    idle(2);
    step(1, 8'h00);                  // R2 writing zero: stop stays set
    idle(1);
    chk("R2 stop after zero write", csr_rd[2], 1'b1);
    step(1, 8'h02); idle(3);         // R4 start alone
    chk("R4 rx up", rx_en, 1'b1);
    step(1, 8'h08); idle(2);         // R8 demand
    step(); txd_fetched = 1; idle(2);
    chk("R8 cleared by fetch", csr_rd[3], 1'b0);
    step(); poll_tick = 1; idle(1);  // R9
    step(); tx_underflow = 1; uflo_keep_tx = 1; idle(2);   // R7 kept
    chk("R7 kept", tx_en, 1'b1);
    step(); tx_underflow = 1; uflo_keep_tx = 0; idle(2);   // R7 dropped
    chk("R7 dropped", tx_en, 1'b0);
    step(1, 8'h08); idle(2);         // R8 write with tx off
    chk("R8 no demand when tx off", csr_rd[3], 1'b0);
    step(1, 8'h07); idle(2);         // R2 stop wins
    chk("R2 stop wins", csr_rd[2:0], 3'b100);
    step(1, 8'h03); idle(4);         // R5 start with init
    chk("R5 rx held", rx_en, 1'b0);
    step(); init_done = 1; idle(1);
    chk("R5 rx still held", rx_en, 1'b0);
    idle(1);
    chk("R5 rx released", rx_en, 1'b1);
    step(1, 8'h04); idle(1);
    rx_disable = 1;
    step(1, 8'h02); idle(3);         // R4 rx disabled
    chk("R4 rx disabled", rx_en, 1'b0);
    rx_disable = 0;
    step(1, 8'h40); irq_flags = 8'h10; irq_mask = 8'h10; idle(2);  // R11 R12
    irq_mask = 8'h00; idle(2);
    chk("R12 irq asserted", irq_n, 1'b0);
    step(1, 8'h00); idle(2);         // R10 clear
    irq_force = 1; idle(2); irq_force = 0;
    step(); soft_rst = 1; wr_en = 1; wr_data = 8'h02; idle(2);    // R13
    chk("R13 soft reset stops", csr_rd[2:1], 2'b10);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step();
      wr_en = (r[3:0] < 3);
      wr_data = {r[31:27] , (r[26:24] == 0) ? 1'b1 : 1'b0, r[22:21]};
      soft_rst = (r[11:4] == 0);
      init_done = r[12] & r[13];
      txd_fetched = r[14] & r[15];
      tx_underflow = (r[19:16] == 0);
      uflo_keep_tx = r[20];
      poll_tick = r[23];
      irq_flags = r[31:24];
      irq_mask = r[7:0] ^ r[15:8];
      irq_force = (r[10:8] == 0);
      rx_disable = (r[6:4] == 0);
      tx_disable = (r[9:7] == 0);
    end
    idle(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule